// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from on-chip sources and stores each one as a 16-byte vector in a circular ring in system memory. It keeps a write pointer and a read pointer, both counted in bytes. The host reads vectors from the ring and then writes its read pointer back to the block. Each vector goes out as four consecutive dword writes on a simple memory port. When write-pointer mirroring is enabled, one more dword write copies the current write pointer to a separate writeback address.

When the ring fills, the block keeps writing and overwrites the oldest entries. It also sets a sticky overflow flag in the top bit of the readable write pointer. Software then restarts parsing from the write pointer plus 16, and clears the flag through the control register. An interrupt line tells the host that the ring holds unconsumed vectors. In level mode the line stays high while work is pending. In rearm mode the line gives a single pulse, and a read-pointer write arms it again.

Top module: `ivr_ring_writer`

## Requirements
- R1: An accepted event is written as four dwords at byte addresses base*256 + wptr + 0, 4, 8 and 12, one per cycle, starting the cycle after acceptance. dword0 = {24'b0, src}, dword1 = {4'b0, data[27:0]}, dword2 = {pasid[15:0], vmid[7:0], ring[7:0]}, dword3 = 0.
- R2: `evt_ready` is high only when the ring enable is set and no vector or writeback write is in progress. An event is accepted when `evt_valid` and `evt_ready` are both high at a clock edge. While the ring is disabled, `evt_valid` causes no memory write.
- R3: On the edge that ends the fourth dword, wptr becomes (wptr + 16) & mask, where mask = (4 << s) - 1. Here s is the size field (log2 of the ring length in dwords), clamped to the range 2..MAX_LOG2_DW.
- R4: If overflow detection is enabled and the advanced wptr equals rptr, the overflow flag is set. The flag reads as bit 31 of the wptr register and stays set while further vectors are still written.
- R5: Writing 1 to control bit 5 clears the overflow flag. The bit always reads back as 0.
- R6: With writeback enabled, the cycle after the fourth dword writes one dword to {wb_hi[7:0], wb_lo[31:0]}. Its data equals the wptr register value after the advance, flag included. With writeback disabled, no fifth write occurs.
- R7: With rearm off, `irq` = interrupt enable AND (wptr != rptr OR overflow flag).
- R8: With rearm on, `irq` rises for exactly one cycle when work is pending. It rises again only after a host write to rptr, and only if work is still pending.
- R9: Host writes to rptr and wptr are masked by the ring mask and cleared to 16-byte alignment. A wptr write also clears the overflow flag. Ring and interrupt enables off with both pointers at 0 leave `irq` and `evt_ready` low.
- R10: Register map, by address:
  - 0 = control: bit0 ring enable, bit1 interrupt enable, bit2 overflow detect, bit3 writeback enable, bit4 rearm, bit5 overflow clear, bits[11:8] size.
  - 1 = base address bits [39:8].
  - 2 = rptr.
  - 3 = wptr (flag in bit 31).
  - 4 = writeback address low.
  - 5 = writeback address high in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken |
| evt_src | input | 8 | Event source id |
| evt_data | input | 28 | Event source data |
| evt_ring | input | 8 | Event ring id |
| evt_vmid | input | 8 | Event VMID |
| evt_pasid | input | 16 | Event PASID |
| mem_we | output | 1 | Memory dword write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Interrupt to the host |

## Verification
On every cycle, the assertions check the following properties:
- The four dword addresses of a vector step by four.
- The write pointer moves by exactly one masked vector stride.
- The overflow flag holds until it is cleared.
- Pointers stay vector-aligned.
- `evt_ready` stays low during memory writes.
- A rearm-mode pulse lasts a single cycle.

The bench scenarios are needed for the rest:
- The packed dword contents.
- The wrap and overflow points at specific ring sizes, including the clamped minimum.
- The writeback word and its absence when disabled.
- The re-firing of the interrupt after a read-pointer write.
- The idle state after disable.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int VEC_DW    = 4;
    localparam int VEC_BYTES = VEC_DW * 4;
    localparam int VEC_BITS  = VEC_DW * 32;
    localparam int CNT_W     = $clog2(VEC_DW);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_WB   = 2'd2
    } eng_st_e;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_BASE = 3'd1;
    localparam logic [2:0] RA_RPTR = 3'd2;
    localparam logic [2:0] RA_WPTR = 3'd3;
    localparam logic [2:0] RA_WBLO = 3'd4;
    localparam logic [2:0] RA_WBHI = 3'd5;

    localparam int CB_RING  = 0;
    localparam int CB_INTR  = 1;
    localparam int CB_OVFEN = 2;
    localparam int CB_WBEN  = 3;
    localparam int CB_REARM = 4;
    localparam int CB_OVCLR = 5;
    localparam int CB_SZLO  = 8;
endpackage

// File: rtl/ivr_pack.sv
module ivr_pack
    import ivr_pkg::*;
(
    input  logic [7:0]          src,
    input  logic [27:0]         data,
    input  logic [7:0]          ring,
    input  logic [7:0]          vmid,
    input  logic [15:0]         pasid,
    output logic [VEC_BITS-1:0] vec
);
    logic [31:0] dw0, dw1, dw2, dw3;

    always_comb begin
        dw0 = {24'h0, src};
        dw1 = {4'h0, data};
        dw2 = {pasid, vmid, ring};
        dw3 = 32'h0;
        vec = {dw3, dw2, dw1, dw0};
    end
endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2_DW = 14,
    parameter int PTR_W       = MAX_LOG2_DW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [PTR_W-1:0] wptr,
    input  logic             ovf,
    output logic             ring_en,
    output logic             intr_en,
    output logic             ovf_en,
    output logic             wb_en,
    output logic             rearm,
    output logic [31:0]      base,
    output logic [39:0]      wb_addr,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] ptr_mask,
    output logic             rptr_wr,
    output logic             wptr_wr,
    output logic             ovf_clr,
    output logic [PTR_W-1:0] ptr_wdata
);
    typedef struct packed {
        logic             ring_en;
        logic             intr_en;
        logic             ovf_en;
        logic             wb_en;
        logic             rearm;
        logic [3:0]       size;
        logic [31:0]      base;
        logic [31:0]      wb_lo;
        logic [7:0]       wb_hi;
        logic [PTR_W-1:0] rptr;
    } regs_t;

    regs_t     r_q, r_d;
    logic [3:0] size_eff;

    always_comb begin
        if (r_q.size < 4'd2)                    size_eff = 4'd2;
        else if (r_q.size > 4'(MAX_LOG2_DW))    size_eff = 4'(MAX_LOG2_DW);
        else                                    size_eff = r_q.size;
        ptr_mask  = PTR_W'(((PTR_W+1)'(4) << size_eff) - (PTR_W+1)'(1));
        ptr_wdata = reg_wdata[PTR_W-1:0] & ptr_mask & ~PTR_W'(VEC_BYTES-1);
        rptr_wr   = reg_wr_en && (reg_addr == RA_RPTR);
        wptr_wr   = reg_wr_en && (reg_addr == RA_WPTR);
        ovf_clr   = reg_wr_en && (reg_addr == RA_CTRL) && reg_wdata[CB_OVCLR];

        r_d = r_q;
        if (reg_wr_en) begin
            case (reg_addr)
                RA_CTRL: begin
                    r_d.ring_en = reg_wdata[CB_RING];
                    r_d.intr_en = reg_wdata[CB_INTR];
                    r_d.ovf_en  = reg_wdata[CB_OVFEN];
                    r_d.wb_en   = reg_wdata[CB_WBEN];
                    r_d.rearm   = reg_wdata[CB_REARM];
                    r_d.size    = reg_wdata[CB_SZLO +: 4];
                end
                RA_BASE: r_d.base  = reg_wdata;
                RA_RPTR: r_d.rptr  = ptr_wdata;
                RA_WBLO: r_d.wb_lo = reg_wdata;
                RA_WBHI: r_d.wb_hi = reg_wdata[7:0];
                default: ;
            endcase
        end

        case (reg_addr)
            RA_CTRL: reg_rdata = {20'h0, r_q.size, 3'b000, r_q.rearm, r_q.wb_en,
                                  r_q.ovf_en, r_q.intr_en, r_q.ring_en};
            RA_BASE: reg_rdata = r_q.base;
            RA_RPTR: reg_rdata = 32'(r_q.rptr);
            RA_WPTR: reg_rdata = {ovf, {(31-PTR_W){1'b0}}, wptr};
            RA_WBLO: reg_rdata = r_q.wb_lo;
            RA_WBHI: reg_rdata = {24'h0, r_q.wb_hi};
            default: reg_rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ring_en = r_q.ring_en;
    assign intr_en = r_q.intr_en;
    assign ovf_en  = r_q.ovf_en;
    assign wb_en   = r_q.wb_en;
    assign rearm   = r_q.rearm;
    assign base    = r_q.base;
    assign wb_addr = {r_q.wb_hi, r_q.wb_lo};
    assign rptr    = r_q.rptr;

    // R9
    rptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rptr[3:0] == 4'h0);
endmodule

// File: rtl/ivr_engine.sv
module ivr_engine
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ring_en,
    input  logic                ovf_en,
    input  logic                wb_en,
    input  logic [PTR_W-1:0]    ptr_mask,
    input  logic [PTR_W-1:0]    rptr,
    input  logic [31:0]         base,
    input  logic [39:0]         wb_addr,
    input  logic                wptr_wr,
    input  logic [PTR_W-1:0]    ptr_wdata,
    input  logic                ovf_clr,
    input  logic                evt_valid,
    input  logic [VEC_BITS-1:0] vec_in,
    output logic                evt_ready,
    output logic                mem_we,
    output logic [39:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    output logic [PTR_W-1:0]    wptr,
    output logic                ovf
);
    typedef struct packed {
        eng_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [PTR_W-1:0]    wptr;
        logic                ovf;
        logic [VEC_BITS-1:0] vec;
    } eng_t;

    eng_t             r_q, r_d;
    logic [PTR_W-1:0] wptr_step;
    logic             last_dw;

    always_comb begin
        r_d       = r_q;
        wptr_step = (r_q.wptr + PTR_W'(VEC_BYTES)) & ptr_mask;
        last_dw   = (r_q.cnt == CNT_W'(VEC_DW-1));
        if (ovf_clr) r_d.ovf = 1'b0;
        case (r_q.st)
            ST_IDLE: if (evt_valid && ring_en) begin
                r_d.vec = vec_in;
                r_d.cnt = '0;
                r_d.st  = ST_VEC;
            end
            ST_VEC: begin
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (last_dw) begin
                    r_d.wptr = wptr_step;
                    if (ovf_en && (wptr_step == rptr)) r_d.ovf = 1'b1;
                    r_d.st = wb_en ? ST_WB : ST_IDLE;
                end
            end
            ST_WB:   r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
        if (wptr_wr) begin
            r_d.wptr = ptr_wdata;
            r_d.ovf  = 1'b0;
        end

        evt_ready = ring_en && (r_q.st == ST_IDLE);
        mem_we    = (r_q.st != ST_IDLE);
        if (r_q.st == ST_WB) begin
            mem_addr  = wb_addr;
            mem_wdata = {r_q.ovf, {(31-PTR_W){1'b0}}, r_q.wptr};
        end else begin
            mem_addr  = {base, 8'h00} + 40'(r_q.wptr) + 40'({r_q.cnt, 2'b00});
            mem_wdata = r_q.vec[32*r_q.cnt +: 32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wptr = r_q.wptr;
    assign ovf  = r_q.ovf;

    // R1
    dword_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_VEC && !last_dw) |=>
        (mem_we && (mem_addr == $past(mem_addr) + 40'd4 || base != $past(base))));

    // R3
    wptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_VEC && last_dw && !wptr_wr) |=>
        (r_q.wptr == (($past(r_q.wptr) + PTR_W'(VEC_BYTES)) & $past(ptr_mask))));

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf && !ovf_clr && !wptr_wr) |=> r_q.ovf);

    // R9
    wptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wptr[3:0] == 4'h0);
endmodule

// File: rtl/ivr_irq.sv
module ivr_irq #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             intr_en,
    input  logic             rearm,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    input  logic             ovf,
    input  logic             rptr_wr,
    output logic             irq
);
    logic armed_q, armed_d;
    logic pending;

    always_comb begin
        pending = (wptr != rptr) || ovf;
        irq     = intr_en && pending && (!rearm || armed_q);
        armed_d = armed_q;
        if (irq)     armed_d = 1'b0;
        if (rptr_wr) armed_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b1;
        else        armed_q <= armed_d;
    end

    // R8
    rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && irq && !rptr_wr) |=> (!irq || !rearm));
endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2_DW = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        evt_valid,
    output logic        evt_ready,
    input  logic [7:0]  evt_src,
    input  logic [27:0] evt_data,
    input  logic [7:0]  evt_ring,
    input  logic [7:0]  evt_vmid,
    input  logic [15:0] evt_pasid,
    output logic        mem_we,
    output logic [39:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        irq
);
    localparam int PTR_W = MAX_LOG2_DW + 2;

    logic                ring_en, intr_en, ovf_en, wb_en, rearm;
    logic [31:0]         base;
    logic [39:0]         wb_addr;
    logic [PTR_W-1:0]    rptr, wptr, ptr_mask, ptr_wdata;
    logic                rptr_wr, wptr_wr, ovf_clr, ovf;
    logic [VEC_BITS-1:0] vec;

    ivr_pack u_pack (
        .src(evt_src), .data(evt_data), .ring(evt_ring),
        .vmid(evt_vmid), .pasid(evt_pasid), .vec(vec)
    );

    ivr_regs #(.MAX_LOG2_DW(MAX_LOG2_DW), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wptr(wptr), .ovf(ovf),
        .ring_en(ring_en), .intr_en(intr_en), .ovf_en(ovf_en), .wb_en(wb_en),
        .rearm(rearm), .base(base), .wb_addr(wb_addr), .rptr(rptr),
        .ptr_mask(ptr_mask), .rptr_wr(rptr_wr), .wptr_wr(wptr_wr),
        .ovf_clr(ovf_clr), .ptr_wdata(ptr_wdata)
    );

    ivr_engine #(.PTR_W(PTR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .ovf_en(ovf_en),
        .wb_en(wb_en), .ptr_mask(ptr_mask), .rptr(rptr), .base(base),
        .wb_addr(wb_addr), .wptr_wr(wptr_wr), .ptr_wdata(ptr_wdata),
        .ovf_clr(ovf_clr), .evt_valid(evt_valid), .vec_in(vec),
        .evt_ready(evt_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wptr(wptr), .ovf(ovf)
    );

    ivr_irq #(.PTR_W(PTR_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .intr_en(intr_en), .rearm(rearm),
        .wptr(wptr), .rptr(rptr), .ovf(ovf), .rptr_wr(rptr_wr), .irq(irq)
    );

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !evt_ready);
endmodule

// File: tb/sim_ivr_ring_writer.sv
module sim_ivr_ring_writer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr_en = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        evt_valid = 0, evt_ready;
    logic [7:0]  evt_src = 0, evt_ring = 0, evt_vmid = 0;
    logic [27:0] evt_data = 0;
    logic [15:0] evt_pasid = 0;
    logic        mem_we, irq;
    logic [39:0] mem_addr;
    logic [31:0] mem_wdata;

    ivr_ring_writer u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0, cyc = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h exp %0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    typedef struct packed {
        logic [39:0] a;
        logic [31:0] d;
        logic        last;
        logic        wb;
        logic [31:0] nw;
        logic        no;
    } wr_t;
    wr_t q[$];
    wr_t cur;
    bit  cur_v = 0, m_acc = 0;
    bit  m_ring, m_intr, m_ovfen, m_wben, m_rearm, m_ovf, m_armed = 1;
    int  m_size, m_wptr, m_rptr;
    logic [31:0] m_base, m_wblo;
    logic [7:0]  m_wbhi;

    function automatic int mask_of(int s);
        int e = (s < 2) ? 2 : ((s > 14) ? 14 : s);
        return (4 << e) - 1;
    endfunction

    function automatic bit irq_exp();
        return m_intr && (m_wptr != m_rptr || m_ovf) && (!m_rearm || m_armed);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); cur_v = 0; m_acc = 0;
            {m_ring, m_intr, m_ovfen, m_wben, m_rearm, m_ovf} = '0;
            m_armed = 1; m_size = 0; m_wptr = 0; m_rptr = 0;
            m_base = 0; m_wblo = 0; m_wbhi = 0;
        end else begin
            automatic bit acc = evt_valid && m_ring && !cur_v;
            automatic int msk = mask_of(m_size);
            automatic bit wr_r = reg_wr_en && reg_addr == 3'd2;
            if (irq_exp()) m_armed = 0;
            if (wr_r) m_armed = 1;
            if (reg_wr_en && reg_addr == 3'd0 && reg_wdata[5]) m_ovf = 0;
            if (cur_v && cur.last) begin m_wptr = cur.nw; m_ovf = cur.no; end
            if (acc) begin
                automatic int nw = (m_wptr + 16) & msk;
                automatic bit no = m_ovf | (m_ovfen && nw == m_rptr);
                automatic logic [39:0] ba = {m_base, 8'h00} + 40'(m_wptr);
                automatic logic [31:0] dws[4];
                dws[0] = {24'h0, evt_src};
                dws[1] = {4'h0, evt_data};
                dws[2] = {evt_pasid, evt_vmid, evt_ring};
                dws[3] = 32'h0;
                for (int k = 0; k < 4; k++)
                    q.push_back('{ba + 40'(4*k), dws[k], k == 3, 1'b0, 32'(nw), no});
                if (m_wben)
                    q.push_back('{{m_wbhi, m_wblo}, {no, 31'(nw)}, 1'b0, 1'b1, 32'(nw), no});
            end
            if (reg_wr_en) begin
                case (reg_addr)
                    3'd0: begin
                        {m_rearm, m_wben, m_ovfen, m_intr, m_ring} = reg_wdata[4:0];
                        m_size = int'(reg_wdata[11:8]);
                    end
                    3'd1: m_base = reg_wdata;
                    3'd2: m_rptr = int'(reg_wdata) & msk & ~15;
                    3'd3: begin m_wptr = int'(reg_wdata) & msk & ~15; m_ovf = 0; end
                    3'd4: m_wblo = reg_wdata;
                    3'd5: m_wbhi = reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (q.size() > 0) begin cur = q.pop_front(); cur_v = 1; end
            else cur_v = 0;
            m_acc = acc;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 ready", 64'(evt_ready), 64'(m_ring && !cur_v));
            chk(m_rearm ? "R8 irq" : "R7 irq", 64'(irq), 64'(irq_exp()));
            chk("R1 mem_we", 64'(mem_we), 64'(cur_v));
            if (cur_v && mem_we) begin
                chk(cur.wb ? "R6 wb addr" : "R1 addr", 64'(mem_addr), 64'(cur.a));
                chk(cur.wb ? "R6 wb data" : "R1 data", 64'(mem_wdata), 64'(cur.d));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++; total++;
            $display("FAIL watchdog: got %0d exp <50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(e));
    endtask

    task automatic send(input logic [7:0] s, input logic [27:0] d, input bit keep);
        @(negedge clk);
        evt_valid = 1; evt_src = s; evt_data = d;
        evt_ring = s + 8'd1; evt_vmid = s ^ 8'h5A; evt_pasid = {s, ~s};
        do @(negedge clk); while (!m_acc);
        if (!keep) evt_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (cur_v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R2 reset ready", 64'(evt_ready), 0);
        chk("R7 reset irq", 64'(irq), 0);
        rd(3'd3, 32'h0, "R10 reset wptr");
        rd(3'd0, 32'h0, "R10 reset ctrl");

        wr(3'd1, 32'h0001_2345);
        wr(3'd4, 32'h0000_1000);
        wr(3'd5, 32'h0000_00AB);
        wr(3'd0, 32'h0000_040F);
        rd(3'd1, 32'h0001_2345, "R10 base");
        rd(3'd4, 32'h0000_1000, "R10 wb lo");
        rd(3'd5, 32'h0000_00AB, "R10 wb hi");
        rd(3'd0, 32'h0000_040F, "R10 ctrl");

        send(8'h11, 28'hABCDEF1, 0); wait_idle();
        send(8'h22, 28'h0000123, 0); wait_idle();
        rd(3'd3, 32'h20, "R3 wptr after two");
        chk("R7 irq pending", 64'(irq), 1);

        wr(3'd2, 32'h20);
        chk("R7 irq consumed", 64'(irq), 0);
        rd(3'd2, 32'h20, "R10 rptr");

        // four vectors wrap the 64-byte ring back onto rptr
        for (int i = 0; i < 4; i++) begin send(8'h30 + 8'(i), 28'(i * 7), 0); wait_idle(); end
        rd(3'd3, 32'h8000_0020, "R4 overflow flag");
        chk("R7 irq on overflow", 64'(irq), 1);
        send(8'h40, 28'hFFFFFFF, 0); wait_idle();
        rd(3'd3, 32'h8000_0030, "R4 sticky overflow");

        wr(3'd0, 32'h0000_042F);
        rd(3'd3, 32'h30, "R5 overflow cleared");
        rd(3'd0, 32'h0000_040F, "R5 clear bit reads 0");

        // writeback off, back-to-back events
        wr(3'd0, 32'h0000_0407);
        send(8'h51, 28'h1, 1);
        send(8'h52, 28'h2, 0); wait_idle();
        rd(3'd3, 32'h10, "R6 no writeback run");

        wr(3'd3, 32'h0000_1237);
        rd(3'd3, 32'h30, "R9 wptr masked");
        wr(3'd2, 32'h5);
        rd(3'd2, 32'h0, "R9 rptr masked");
        wr(3'd2, 32'h30);

        // rearm mode
        wr(3'd0, 32'h0000_0417);
        send(8'h61, 28'h61, 0); wait_idle();
        repeat (2) @(negedge clk);
        chk("R8 pulse over", 64'(irq), 0);
        wr(3'd2, 32'h20);
        chk("R8 refire", 64'(irq), 1);
        @(negedge clk);
        chk("R8 single cycle", 64'(irq), 0);

        // size 0 clamps to a one-vector ring
        wr(3'd0, 32'h0000_0007);
        wr(3'd3, 32'h0);
        wr(3'd2, 32'h0);
        send(8'h71, 28'h71, 0); wait_idle();
        rd(3'd3, 32'h8000_0000, "R3 clamp wrap R4");

        // disable and zero pointers
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd2, 32'h0);
        rd(3'd3, 32'h0, "R9 idle wptr");
        chk("R9 idle irq", 64'(irq), 0);
        evt_valid = 1;
        repeat (8) @(negedge clk);
        chk("R2 disabled ready", 64'(evt_ready), 0);
        chk("R2 disabled no write", 64'(mem_we), 0);
        evt_valid = 0;

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule